// File: doc/BRIEF.md
# Serial Programming Command Target

This block is the target end of a four-byte serial programming protocol. It sits in front of a model of an on-chip program store and a byte-wide data store. An external programmer drives a mode-0 serial clock and data line and an active-low programming reset. The target samples the serial clock with the system clock. It collects each instruction as four bytes, shifted MSB first, and answers on the serial output. During the third byte it echoes the second byte, so the programmer can check that the two sides agree on byte alignment. Read results come out during the fourth byte.

Program memory is written through a page buffer. The programmer first fills the buffer with low and high data bytes, one word at a time, and then commits the whole buffer to one page. The data store is written one byte at a time, and each write replaces the old value. A write takes time to complete, which is modelled as a countdown in system clocks. While that countdown runs, a read of the page or byte being written returns 0xFF. A chip erase sets every location to 0xFF. Fixed identification and configuration bytes come from parameters.

Top module: `spi_prog_target`

## Requirements
- R1: An instruction is exactly 32 serial bits, taken as four bytes MSB first. MOSI is sampled on the rising SCK edge and MISO changes after the falling edge. Framing restarts at byte 1 after every 32 bits, whatever the content.
- R2: During byte 3 of every frame, MISO shifts out the byte received as byte 2. During bytes 1 and 2, MISO is 0x00.
- R3: Programming mode is entered only by a frame whose byte 1 is 0xAC and byte 2 is 0x53. Until then, no instruction changes any storage and byte 4 reads 0x00.
- R4: While prog_rst_n is high, programming mode is cleared, framing is held at bit 0, MISO stays 0 and all serial traffic is ignored. After prog_rst_n goes low, a new enable frame is needed.
- R5: Byte 1 0x40 loads the low byte and 0x48 loads the high byte of page-buffer word byte3[PAGE_AW-1:0], with data from byte 4.
- R6: Byte 1 0x4C copies the whole page buffer into the page selected by word address {byte2,byte3}, using address bits PROG_AW-1 down to PAGE_AW. The page buffer then reads back as 0xFFFF in every word.
- R7: Byte 1 0x20 returns the low byte and 0x28 returns the high byte of program word {byte2,byte3} modulo the program size, in byte 4.
- R8: Byte 1 0xC0 writes byte 4 to data address {byte2,byte3} modulo EE_DEPTH, replacing the old value. Byte 1 0xA0 reads that address in byte 4.
- R9: For FLASH_WAIT_CYC clocks after a page commit, a read of any word in that page returns 0xFF. For EE_WAIT_CYC clocks after a data write, a read of that address returns 0xFF. Other locations read normally during these windows.
- R10: A frame with byte 1 0xAC and byte2[7:5]=100 sets every program word, data byte and page-buffer word to all ones.
- R11: Byte 1 0x30 returns signature byte byte3[1:0], taken from SIGNATURE[8*b+:8]. Fixed bytes are returned as follows:

  | Byte 1 | Byte 2 | Value returned |
  |--------|--------|----------------|
  | 0x58   | 0x00   | LOCK_BYTE      |
  | 0x50   | 0x00   | FUSE_LO        |
  | 0x58   | 0x08   | FUSE_HI        |
  | 0x50   | 0x08   | FUSE_EXT       |

  Any other opcode returns 0x00 and changes nothing.
- R12: After rst, MISO is 0, programming mode is off, and every program and data location reads 0xFF.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| sck | input | 1 | Serial clock from the programmer, mode 0 |
| mosi | input | 1 | Serial data into the target |
| prog_rst_n | input | 1 | Active-low programming reset; low keeps programming mode available |
| miso | output | 1 | Serial data out of the target, registered |

## Verification
The bench first sends a write and an enable with the wrong key before programming mode is entered. A target that accepted either would later read back a value instead of 0xFF.

It reads a page while that page is still being committed, and reads a neighbouring page in the same window. A busy check that is too wide blanks the neighbour; one that is missing returns the new data too early.

It recommits a page without reloading the buffer, which catches a buffer that keeps its old contents after a commit. It also drops programming reset in the middle of a frame and checks the echo afterwards. A target that keeps its partial bit count would then show a misaligned echo.

// File: rtl/spi_prog_pkg.sv
package spi_prog_pkg;
  localparam logic [7:0] OP_ENTER   = 8'hAC;
  localparam logic [7:0] ENTER_KEY  = 8'h53;
  localparam logic [7:0] OP_LOAD_LO = 8'h40;
  localparam logic [7:0] OP_LOAD_HI = 8'h48;
  localparam logic [7:0] OP_COMMIT  = 8'h4C;
  localparam logic [7:0] OP_RD_LO   = 8'h20;
  localparam logic [7:0] OP_RD_HI   = 8'h28;
  localparam logic [7:0] OP_EE_RD   = 8'hA0;
  localparam logic [7:0] OP_EE_WR   = 8'hC0;
  localparam logic [7:0] OP_SIG     = 8'h30;
  localparam logic [7:0] OP_CFG_A   = 8'h50;
  localparam logic [7:0] OP_CFG_B   = 8'h58;

  typedef enum logic [2:0] {
    WR_NONE   = 3'd0,
    WR_LOAD   = 3'd1,
    WR_COMMIT = 3'd2,
    WR_EE     = 3'd3,
    WR_ERASE  = 3'd4
  } wr_kind_e;

  typedef struct packed {
    wr_kind_e    kind;
    logic        hi;
    logic [15:0] addr;
    logic [7:0]  data;
  } wr_req_t;
endpackage

// File: rtl/spi_prog_shifter.sv
module spi_prog_shifter (
  input  logic       clk,
  input  logic       rst,
  input  logic       sck,
  input  logic       mosi,
  input  logic       frame_clr,
  input  logic       tx_load,
  input  logic [7:0] tx_byte,
  output logic       miso,
  output logic       byte_done,
  output logic [1:0] byte_idx,
  output logic [7:0] rx_byte
);
  logic [2:0] sck_q;
  logic [1:0] mosi_q;
  logic [6:0] sh;
  logic [4:0] bit_cnt;
  logic [7:0] tx;
  logic       rise, fall;

  assign rise = sck_q[1] & ~sck_q[2];
  assign fall = ~sck_q[1] & sck_q[2];

  always_ff @(posedge clk) begin
    if (rst) begin
      sck_q  <= '0;
      mosi_q <= '0;
    end else begin
      sck_q  <= {sck_q[1:0], sck};
      mosi_q <= {mosi_q[0], mosi};
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sh        <= '0;
      bit_cnt   <= '0;
      tx        <= '0;
      miso      <= 1'b0;
      byte_done <= 1'b0;
      byte_idx  <= '0;
      rx_byte   <= '0;
    end else begin
      byte_done <= 1'b0;
      if (frame_clr) begin
        bit_cnt <= '0;
        tx      <= '0;
        miso    <= 1'b0;
      end else begin
        if (rise) begin
          sh      <= {sh[5:0], mosi_q[1]};
          bit_cnt <= bit_cnt + 5'd1;
          if (bit_cnt[2:0] == 3'd7) begin
            byte_done <= 1'b1;
            byte_idx  <= bit_cnt[4:3];
            rx_byte   <= {sh, mosi_q[1]};
          end
        end
        if (tx_load) begin
          tx <= tx_byte;
        end else if (fall) begin
          miso <= tx[7];
          tx   <= {tx[6:0], 1'b0};
        end
      end
    end
  end
endmodule

// File: rtl/spi_prog_mem.sv
module spi_prog_mem
  import spi_prog_pkg::*;
#(
  parameter int PAGE_WORDS     = 8,
  parameter int PROG_PAGES     = 4,
  parameter int EE_DEPTH       = 16,
  parameter int FLASH_WAIT_CYC = 1000,
  parameter int EE_WAIT_CYC    = 1500,
  localparam int PAGE_AW = $clog2(PAGE_WORDS),
  localparam int PROG_AW = $clog2(PAGE_WORDS * PROG_PAGES),
  localparam int EE_AW   = $clog2(EE_DEPTH),
  localparam int FL_CW   = $clog2(FLASH_WAIT_CYC + 1),
  localparam int EE_CW   = $clog2(EE_WAIT_CYC + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  wr_req_t          wr,
  input  logic [15:0]      rd_addr,
  input  logic             rd_hi,
  output logic [7:0]       prog_q,
  output logic [7:0]       ee_q,
  output logic [FL_CW-1:0] fl_cnt,
  output logic [EE_CW-1:0] ee_cnt
);
  localparam int PROG_WORDS = PAGE_WORDS * PROG_PAGES;
  localparam int PG_W       = PROG_AW - PAGE_AW;

  logic [15:0]      prog_mem [PROG_WORDS];
  logic [7:0]       ee_mem   [EE_DEPTH];
  logic [15:0]      page_buf [PAGE_WORDS];
  logic [PG_W-1:0]  fl_page;
  logic [EE_AW-1:0] ee_busy_addr;
  logic [15:0]      prog_word;
  logic             unused_addr;

  assign unused_addr = ^{wr.addr, rd_addr};

  always_ff @(posedge clk) begin
    if (rst || wr.kind == WR_ERASE) begin
      for (int i = 0; i < PROG_WORDS; i++) prog_mem[i] <= 16'hFFFF;
      for (int i = 0; i < EE_DEPTH; i++)   ee_mem[i]   <= 8'hFF;
      for (int i = 0; i < PAGE_WORDS; i++) page_buf[i] <= 16'hFFFF;
    end else begin
      case (wr.kind)
        WR_LOAD: begin
          if (wr.hi) page_buf[wr.addr[PAGE_AW-1:0]][15:8] <= wr.data;
          else       page_buf[wr.addr[PAGE_AW-1:0]][7:0]  <= wr.data;
        end
        WR_COMMIT: begin
          for (int i = 0; i < PAGE_WORDS; i++) begin
            prog_mem[{wr.addr[PROG_AW-1:PAGE_AW], PAGE_AW'(i)}] <= page_buf[i];
            page_buf[i] <= 16'hFFFF;
          end
        end
        WR_EE:   ee_mem[wr.addr[EE_AW-1:0]] <= wr.data;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      fl_cnt       <= '0;
      ee_cnt       <= '0;
      fl_page      <= '0;
      ee_busy_addr <= '0;
    end else begin
      if (wr.kind == WR_COMMIT) begin
        fl_cnt  <= FL_CW'(FLASH_WAIT_CYC);
        fl_page <= wr.addr[PROG_AW-1:PAGE_AW];
      end else if (fl_cnt != '0) begin
        fl_cnt <= fl_cnt - 1'b1;
      end
      if (wr.kind == WR_EE) begin
        ee_cnt       <= EE_CW'(EE_WAIT_CYC);
        ee_busy_addr <= wr.addr[EE_AW-1:0];
      end else if (ee_cnt != '0) begin
        ee_cnt <= ee_cnt - 1'b1;
      end
    end
  end

  assign prog_word = prog_mem[rd_addr[PROG_AW-1:0]];
  assign prog_q = (fl_cnt != '0 && rd_addr[PROG_AW-1:PAGE_AW] == fl_page) ? 8'hFF :
                  (rd_hi ? prog_word[15:8] : prog_word[7:0]);
  assign ee_q   = (ee_cnt != '0 && rd_addr[EE_AW-1:0] == ee_busy_addr) ? 8'hFF :
                  ee_mem[rd_addr[EE_AW-1:0]];
endmodule

// File: rtl/spi_prog_target.sv
module spi_prog_target
  import spi_prog_pkg::*;
#(
  parameter int          PAGE_WORDS     = 8,
  parameter int          PROG_PAGES     = 4,
  parameter int          EE_DEPTH       = 16,
  parameter int          FLASH_WAIT_CYC = 1000,
  parameter int          EE_WAIT_CYC    = 1500,
  parameter logic [31:0] SIGNATURE      = 32'h0002971E,
  parameter logic [7:0]  LOCK_BYTE      = 8'hFF,
  parameter logic [7:0]  FUSE_LO        = 8'hE1,
  parameter logic [7:0]  FUSE_HI        = 8'h99,
  parameter logic [7:0]  FUSE_EXT       = 8'hFD
) (
  input  logic clk,
  input  logic rst,
  input  logic sck,
  input  logic mosi,
  input  logic prog_rst_n,
  output logic miso
);
  localparam int FL_CW = $clog2(FLASH_WAIT_CYC + 1);
  localparam int EE_CW = $clog2(EE_WAIT_CYC + 1);

  logic [1:0]       pr_q;
  logic             released;
  logic             byte_done, frame_done, prog_en;
  logic [1:0]       byte_idx;
  logic [7:0]       rx_byte, b1, b2, b3, resp, tx_byte, prog_q, ee_q;
  logic [FL_CW-1:0] fl_cnt;
  logic [EE_CW-1:0] ee_cnt;
  wr_req_t          wr;

  assign released   = pr_q[1];
  assign frame_done = byte_done && byte_idx == 2'd3;

  always_ff @(posedge clk) begin
    if (rst) pr_q <= 2'b11;
    else     pr_q <= {pr_q[0], prog_rst_n};
  end

  spi_prog_shifter shifter_i (
    .clk(clk), .rst(rst), .sck(sck), .mosi(mosi), .frame_clr(released),
    .tx_load(byte_done), .tx_byte(tx_byte), .miso(miso),
    .byte_done(byte_done), .byte_idx(byte_idx), .rx_byte(rx_byte)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      prog_en <= 1'b0;
      b1 <= '0;
      b2 <= '0;
      b3 <= '0;
    end else if (released) begin
      prog_en <= 1'b0;
    end else if (byte_done) begin
      case (byte_idx)
        2'd0: b1 <= rx_byte;
        2'd1: b2 <= rx_byte;
        2'd2: b3 <= rx_byte;
        default: if (b1 == OP_ENTER && b2 == ENTER_KEY) prog_en <= 1'b1;
      endcase
    end
  end

  always_comb begin
    resp = 8'h00;
    if (prog_en) begin
      case (b1)
        OP_RD_LO, OP_RD_HI: resp = prog_q;
        OP_EE_RD:           resp = ee_q;
        OP_SIG:             resp = SIGNATURE[{rx_byte[1:0], 3'b000} +: 8];
        OP_CFG_A: begin
          if (b2 == 8'h00)      resp = FUSE_LO;
          else if (b2 == 8'h08) resp = FUSE_EXT;
        end
        OP_CFG_B: begin
          if (b2 == 8'h00)      resp = LOCK_BYTE;
          else if (b2 == 8'h08) resp = FUSE_HI;
        end
        default: ;
      endcase
    end
  end

  always_comb begin
    case (byte_idx)
      2'd1:    tx_byte = rx_byte;
      2'd2:    tx_byte = resp;
      default: tx_byte = 8'h00;
    endcase
  end

  always_comb begin
    wr      = '0;
    wr.kind = WR_NONE;
    wr.hi   = b1[3];
    wr.addr = {b2, b3};
    wr.data = rx_byte;
    if (frame_done && prog_en) begin
      if (b1 == OP_ENTER && b2[7:5] == 3'b100) begin
        wr.kind = WR_ERASE;
      end else if (b1 == OP_LOAD_LO || b1 == OP_LOAD_HI) begin
        wr.kind = WR_LOAD;
        wr.addr = {9'd0, b3[6:0]};
      end else if (b1 == OP_COMMIT) begin
        wr.kind = WR_COMMIT;
      end else if (b1 == OP_EE_WR) begin
        wr.kind = WR_EE;
      end
    end
  end

  spi_prog_mem #(
    .PAGE_WORDS(PAGE_WORDS), .PROG_PAGES(PROG_PAGES), .EE_DEPTH(EE_DEPTH),
    .FLASH_WAIT_CYC(FLASH_WAIT_CYC), .EE_WAIT_CYC(EE_WAIT_CYC)
  ) mem_i (
    .clk(clk), .rst(rst), .wr(wr), .rd_addr({b2, rx_byte}), .rd_hi(b1[3]),
    .prog_q(prog_q), .ee_q(ee_q), .fl_cnt(fl_cnt), .ee_cnt(ee_cnt)
  );
endmodule

// File: rtl/spi_prog_target_chk.sv
module spi_prog_target_chk #(
  parameter int FLASH_WAIT_CYC = 1000,
  parameter int EE_WAIT_CYC    = 1500,
  localparam int FL_CW = $clog2(FLASH_WAIT_CYC + 1),
  localparam int EE_CW = $clog2(EE_WAIT_CYC + 1)
) (
  input logic             clk,
  input logic             rst,
  input logic             released,
  input logic             prog_en,
  input logic             frame_done,
  input logic [7:0]       b1,
  input logic [7:0]       b2,
  input logic             miso,
  input logic [FL_CW-1:0] fl_cnt,
  input logic [EE_CW-1:0] ee_cnt
);
  logic commit_now, ee_now, key_now;
  assign commit_now = frame_done && prog_en && b1 == 8'h4C;
  assign ee_now     = frame_done && prog_en && b1 == 8'hC0;
  assign key_now    = frame_done && b1 == 8'hAC && b2 == 8'h53;

  AST_EXIT_ON_RELEASE: assert property (@(posedge clk) disable iff (rst) released |=> !prog_en); // R4
  AST_MISO_QUIET_RELEASED: assert property (@(posedge clk) disable iff (rst) released |=> !miso); // R4
  AST_ENABLE_NEEDS_KEY: assert property (@(posedge clk) disable iff (rst) (!prog_en && !key_now) |=> !prog_en); // R3
  AST_COMMIT_ARMS_TIMER: assert property (@(posedge clk) disable iff (rst) commit_now |=> fl_cnt == FL_CW'(FLASH_WAIT_CYC)); // R9
  AST_EE_ARMS_TIMER: assert property (@(posedge clk) disable iff (rst) ee_now |=> ee_cnt == EE_CW'(EE_WAIT_CYC)); // R9
  AST_FLASH_TIMER_STEP: assert property (@(posedge clk) disable iff (rst) (fl_cnt != '0 && !commit_now) |=> fl_cnt == $past(fl_cnt) - 1'b1); // R9
  AST_EE_TIMER_STEP: assert property (@(posedge clk) disable iff (rst) (ee_cnt != '0 && !ee_now) |=> ee_cnt == $past(ee_cnt) - 1'b1); // R9
endmodule

bind spi_prog_target spi_prog_target_chk #(
  .FLASH_WAIT_CYC(FLASH_WAIT_CYC), .EE_WAIT_CYC(EE_WAIT_CYC)
) chk_i (
  .clk(clk), .rst(rst), .released(released), .prog_en(prog_en),
  .frame_done(frame_done), .b1(b1), .b2(b2), .miso(miso),
  .fl_cnt(fl_cnt), .ee_cnt(ee_cnt)
);

// File: tb/spi_prog_target_tb_top.sv
`timescale 1ns/1ps
module spi_prog_target_tb_top;
  localparam int HALF = 8;
  localparam int FW = 1000;
  localparam int EW = 1500;

  logic clk = 1'b0, rst = 1'b1, sck = 1'b0, mosi = 1'b0, prog_rst_n = 1'b1;
  logic miso;
  always #2 clk = ~clk;

  spi_prog_target dut_i (.clk(clk), .rst(rst), .sck(sck), .mosi(mosi),
                         .prog_rst_n(prog_rst_n), .miso(miso));

  int nchk = 0, nerr = 0;
  longint cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  // behavioural reference state
  logic [15:0] m_prog [32];
  logic [7:0]  m_ee   [16];
  logic [15:0] m_buf  [8];
  logic        m_en = 1'b0, m_rel = 1'b1, mon_rel = 1'b0;
  longint      fl_end = 0, ee_end = 0;
  int          fl_page = 0, ee_addr = 0;

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    nchk++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s: got %02h expected %02h at cycle %0d", req, act, exp, cyc);
    end
  endtask

  always @(negedge clk) if (mon_rel) check("R4 miso while released", {7'd0, miso}, 8'h00);

  function automatic logic [7:0] m_resp(input logic [7:0] o1, o2, o3);
    logic [15:0] a = {o2, o3};
    int wa = int'(a) % 32;
    int ea = int'(a) % 16;
    if (!m_en) return 8'h00;
    case (o1)
      8'h20, 8'h28: begin
        if (cyc < fl_end && wa / 8 == fl_page) return 8'hFF;
        return o1[3] ? m_prog[wa][15:8] : m_prog[wa][7:0];
      end
      8'hA0: return (cyc < ee_end && ea == ee_addr) ? 8'hFF : m_ee[ea];
      8'h30: case (o3[1:0]) 2'd0: return 8'h1E; 2'd1: return 8'h97; 2'd2: return 8'h02; default: return 8'h00; endcase
      8'h50: return (o2 == 8'h00) ? 8'hE1 : (o2 == 8'h08) ? 8'hFD : 8'h00;
      8'h58: return (o2 == 8'h00) ? 8'hFF : (o2 == 8'h08) ? 8'h99 : 8'h00;
      default: return 8'h00;
    endcase
  endfunction

  task automatic m_exec(input logic [7:0] o1, o2, o3, o4);
    logic [15:0] a = {o2, o3};
    if (m_rel) return;
    if (o1 == 8'hAC && o2 == 8'h53) begin m_en = 1'b1; return; end
    if (!m_en) return;
    if (o1 == 8'hAC && o2[7:5] == 3'b100) begin
      for (int i = 0; i < 32; i++) m_prog[i] = 16'hFFFF;
      for (int i = 0; i < 16; i++) m_ee[i] = 8'hFF;
      for (int i = 0; i < 8; i++) m_buf[i] = 16'hFFFF;
    end else if (o1 == 8'h40) m_buf[o3 % 8][7:0] = o4;
    else if (o1 == 8'h48) m_buf[o3 % 8][15:8] = o4;
    else if (o1 == 8'h4C) begin
      fl_page = (int'(a) % 32) / 8;
      for (int i = 0; i < 8; i++) begin m_prog[fl_page * 8 + i] = m_buf[i]; m_buf[i] = 16'hFFFF; end
      fl_end = cyc + FW;
    end else if (o1 == 8'hC0) begin
      ee_addr = int'(a) % 16;
      m_ee[ee_addr] = o4;
      ee_end = cyc + EW;
    end
  endtask

  task automatic send_bit(input logic b, output logic got);
    mosi = b;
    repeat (HALF) @(negedge clk);
    got = miso;
    sck = 1'b1;
    repeat (HALF) @(negedge clk);
    sck = 1'b0;
  endtask

  task automatic xfer(input logic [7:0] o1, o2, o3, o4, input string req);
    logic [7:0] tx [4];
    logic [7:0] got, exp;
    logic g;
    tx[0] = o1; tx[1] = o2; tx[2] = o3; tx[3] = o4;
    for (int k = 0; k < 4; k++) begin
      exp = 8'h00;
      if (!m_rel && k == 2) exp = o2;
      if (!m_rel && k == 3) exp = m_resp(o1, o2, o3);
      for (int j = 7; j >= 0; j--) begin
        send_bit(tx[k][j], g);
        got[j] = g;
      end
      if (k == 2) check({"R2 echo/", req}, got, exp);
      else if (k == 3) check(req, got, exp);
      else check("R1 quiet head byte", got, exp);
    end
    m_exec(o1, o2, o3, o4);
  endtask

  task automatic set_prog(input logic v);
    if (!v) mon_rel = 1'b0;
    prog_rst_n = v;
    repeat (10) @(negedge clk);
    m_rel = v;
    if (v) begin m_en = 1'b0; mon_rel = 1'b1; end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nerr++;
    nchk++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("  Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end

  initial begin
    logic g;
    for (int i = 0; i < 32; i++) m_prog[i] = 16'hFFFF;
    for (int i = 0; i < 16; i++) m_ee[i] = 8'hFF;
    for (int i = 0; i < 8; i++) m_buf[i] = 16'hFFFF;
    idle(5);
    rst = 1'b0;
    idle(3);
    check("R12 miso after reset", {7'd0, miso}, 8'h00);
    set_prog(1'b0);
    // R3: nothing works before the key
    xfer(8'hA0, 8'h00, 8'h05, 8'h00, "R3 read before enable");
    xfer(8'hC0, 8'h00, 8'h05, 8'h12, "R3 write before enable");
    xfer(8'hAC, 8'h54, 8'h00, 8'h00, "R3 wrong key");
    xfer(8'hA0, 8'h00, 8'h05, 8'h00, "R3 still disabled");
    xfer(8'hAC, 8'h53, 8'h00, 8'h00, "R2 enable");
    xfer(8'hA0, 8'h00, 8'h05, 8'h00, "R3 ignored write, R12 erased");
    xfer(8'h20, 8'h00, 8'h03, 8'h00, "R12 program erased");
    // R11 fixed bytes
    for (int b = 0; b < 4; b++) xfer(8'h30, 8'h00, 8'(b), 8'h00, "R11 signature");
    xfer(8'h58, 8'h00, 8'h00, 8'h00, "R11 lock");
    xfer(8'h50, 8'h00, 8'h00, 8'h00, "R11 fuse low");
    xfer(8'h58, 8'h08, 8'h00, 8'h00, "R11 fuse high");
    xfer(8'h50, 8'h08, 8'h00, 8'h00, "R11 fuse ext");
    xfer(8'h77, 8'h12, 8'h34, 8'h56, "R11 unknown opcode");
    // R5 fill buffer, R6 commit page 0
    for (int w = 0; w < 8; w++) begin
      xfer(8'h40, 8'h00, 8'(w), 8'(w * 3 + 1), "R5 load low");
      xfer(8'h48, 8'h00, 8'(w), 8'(8'hA0 + w), "R5 load high");
    end
    xfer(8'h4C, 8'h00, 8'h00, 8'h00, "R6 commit page 0");
    xfer(8'h20, 8'h00, 8'h02, 8'h00, "R9 read busy page");
    idle(FW + 200);
    xfer(8'h20, 8'h00, 8'h00, 8'h00, "R7 read low w0");
    xfer(8'h28, 8'h00, 8'h05, 8'h00, "R7 read high w5");
    xfer(8'h20, 8'h00, 8'h07, 8'h00, "R7 read low w7");
    xfer(8'h28, 8'h01, 8'h02, 8'h00, "R7 address wrap");
    // page 1 commit with low address bits set
    xfer(8'h40, 8'h00, 8'h82, 8'h3C, "R5 index from low bits");
    xfer(8'h48, 8'h00, 8'h02, 8'hC3, "R5 load high");
    xfer(8'h4C, 8'h00, 8'h0D, 8'h00, "R6 commit page 1");
    xfer(8'h20, 8'h00, 8'h05, 8'h00, "R9 other page readable");
    xfer(8'h28, 8'h00, 8'h0A, 8'h00, "R9 busy page reads FF");
    idle(FW + 200);
    xfer(8'h20, 8'h00, 8'h0A, 8'h00, "R6 page 1 low");
    xfer(8'h28, 8'h00, 8'h0A, 8'h00, "R6 page 1 high");
    // recommit page 0 with empty buffer
    xfer(8'h4C, 8'h00, 8'h01, 8'h00, "R6 recommit");
    idle(FW + 200);
    xfer(8'h20, 8'h00, 8'h00, 8'h00, "R6 buffer refilled");
    // data memory
    xfer(8'hC0, 8'h00, 8'h07, 8'h11, "R8 write 7");
    idle(EW + 200);
    xfer(8'hC0, 8'h0F, 8'h03, 8'h5A, "R8 write 3");
    xfer(8'hA0, 8'h00, 8'h03, 8'h00, "R9 busy byte");
    xfer(8'hA0, 8'h00, 8'h07, 8'h00, "R9 other byte");
    idle(EW + 200);
    xfer(8'hA0, 8'h00, 8'h03, 8'h00, "R8 read 3");
    xfer(8'hC0, 8'h00, 8'h03, 8'h0F, "R8 overwrite");
    idle(EW + 200);
    xfer(8'hA0, 8'h00, 8'h13, 8'h00, "R8 overwritten value");
    // R4 release mid-frame and realign
    for (int j = 0; j < 12; j++) send_bit(1'b1, g);
    set_prog(1'b1);
    xfer(8'hC0, 8'h00, 8'h07, 8'h99, "R4 traffic while released");
    set_prog(1'b0);
    xfer(8'hA0, 8'h00, 8'h07, 8'h00, "R4 disabled after release");
    xfer(8'hAC, 8'h53, 8'h00, 8'h00, "R1 realigned enable");
    xfer(8'hA0, 8'h00, 8'h07, 8'h00, "R4 released write ignored");
    // R10 chip erase
    xfer(8'hAC, 8'h80, 8'h00, 8'h00, "R10 erase");
    xfer(8'h20, 8'h00, 8'h0A, 8'h00, "R10 program erased");
    xfer(8'hA0, 8'h00, 8'h07, 8'h00, "R10 data erased");
    idle(20);
    $display("  Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end
endmodule